// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block moves 8-bit characters between a parallel host side and a three-wire serial link: one data-out line, one data-in line and a serial clock that both directions share. The serial clock comes from one of two places. An internal divider can produce it and drive it onto the clock pin. Or, when a select bit is set, the block takes it from outside through that same pin. The transmitter and the receiver share this clock and are otherwise independent, so data can flow both ways at once.

Each direction has a one-character holding register in front of its shift register. The host can therefore write the next character, or read the last one, while a transfer is in progress, and characters can follow one another with no pause on the line. Three flags report status: transmit-empty, receive-full and overrun. When only the receiver is enabled and the internal clock is selected, the block clocks characters in without stopping until the receiver is disabled.

Top module: `sync_serial_xcvr`

## Requirements
- R1: Each transmitted character is exactly 8 bits, sent least significant bit first. Every bit changes only after a falling serial-clock edge and is stable at the following rising edge.
- R2: The receiver samples `sd_in` on each rising serial-clock edge, least significant bit first. After the 8th sample it presents the character on `rx_data` and sets `rx_full`. A one-cycle `rx_rd` pulse clears `rx_full`.
- R3: With `ext_clk_sel`=0 the clock pin is driven (`sck_oe`=1). The serial clock has a period of 2*(`div_n`+1) system clocks and is high whenever no character is moving.
- R4: With the internal clock, each character gets exactly 8 clock pulses. The clock stops high after the 8th rising edge when no further character is due.
- R5: After the last bit of a character, `sd_out` keeps that bit's level until the next character starts.
- R6: `tx_empty` is 1 after reset and goes to 1 when the holding register is copied into the shift register. A character written before the current one ends follows it with no idle clock period.
- R7: With `rx_en`=1, `tx_en`=0 and the internal clock, the serial clock runs continuously. It stops, high, after `rx_en` is cleared.
- R8: If a character completes while `rx_full`=1, `rx_overrun` is set, `rx_data` keeps the unread character and the new one is dropped. `rx_rd` clears both flags.
- R9: With `ext_clk_sel`=1, `sck_oe`=0 and shifting follows the edges on `sck_in` after a two-flop synchroniser. With no edges on `sck_in`, nothing shifts and a written character stays pending.
- R10: After reset: `tx_empty`=1, `rx_full`=0, `rx_overrun`=0, `sck_out`=1 and `sd_out`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_sel | input | 1 | 1 = external serial clock on `sck_in`, 0 = internal divider |
| div_n | input | 8 | Divisor N; internal serial clock period is 2*(N+1) system clocks |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Character to transmit |
| tx_empty | output | 1 | Transmit holding register free |
| rx_rd | input | 1 | Read acknowledge; clears `rx_full` and `rx_overrun` |
| rx_data | output | 8 | Last received character |
| rx_full | output | 1 | Unread character in `rx_data` |
| rx_overrun | output | 1 | A character was lost because `rx_full` was still set |
| sck_in | input | 1 | Serial clock from the pin (external mode) |
| sck_out | output | 1 | Serial clock to the pin (internal mode) |
| sck_oe | output | 1 | Clock pin output enable |
| sd_out | output | 1 | Serial data out |
| sd_in | input | 1 | Serial data in |

## Verification
The bench builds the block with its default 8-bit divisor width. At run time it uses divisors 1 and 3, which makes a serial-clock period short enough to stream many characters and lets it measure the period as 4 and as 8 system clocks on every rising edge of a burst, across character boundaries. In the full-duplex runs `sd_out` is looped back to `sd_in`, so each character is checked on the wire and again after it is received. An external clock with a period of 20 system clocks exercises the synchroniser path, including a stretch with no edges at all.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  localparam int CHAR_BITS = 8;
  localparam int IDX_W     = $clog2(CHAR_BITS);
  typedef logic [CHAR_BITS-1:0] char_t;
  typedef logic [IDX_W-1:0]     idx_t;
endpackage

// File: rtl/ssx_clkgen.sv
module ssx_clkgen
  import ssx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_sel,
  input  logic [DIV_W-1:0] div,
  input  logic             want_tx,
  input  logic             rx_only,
  input  logic             sck_in,
  output logic             fall_p,
  output logic             rise_p,
  output logic             sck_o
);
  localparam idx_t LAST = idx_t'(CHAR_BITS - 1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;
  logic             act_q, act_d;
  idx_t             edg_q, edg_d;
  logic [2:0]       sync_q, sync_d;
  logic             int_fall, int_rise, start;

  assign start = want_tx | rx_only;

  always_comb begin
    cnt_d    = cnt_q;
    sck_d    = sck_q;
    act_d    = act_q;
    edg_d    = edg_q;
    int_fall = 1'b0;
    int_rise = 1'b0;
    sync_d   = {sync_q[1:0], sck_in};
    if (ext_sel) begin
      act_d = 1'b0;
      sck_d = 1'b1;
      cnt_d = '0;
      edg_d = '0;
    end else if (!act_q) begin
      if (start) begin
        act_d = 1'b1;
        cnt_d = '0;
        edg_d = '0;
      end
    end else if (cnt_q == div) begin
      cnt_d = '0;
      sck_d = ~sck_q;
      if (sck_q) begin
        int_fall = 1'b1;
      end else begin
        int_rise = 1'b1;
        if (edg_q == LAST) begin
          edg_d = '0;
          if (!start) act_d = 1'b0;
        end else begin
          edg_d = edg_q + idx_t'(1);
        end
      end
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sck_q  <= 1'b1;
      act_q  <= 1'b0;
      edg_q  <= '0;
      sync_q <= 3'b111;
    end else begin
      cnt_q  <= cnt_d;
      sck_q  <= sck_d;
      act_q  <= act_d;
      edg_q  <= edg_d;
      sync_q <= sync_d;
    end
  end

  assign fall_p = ext_sel ? (sync_q[2] & ~sync_q[1]) : int_fall;
  assign rise_p = ext_sel ? (~sync_q[2] & sync_q[1]) : int_rise;
  assign sck_o  = sck_q;

  // R3
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel && !act_q) |-> sck_q);

  // R4
  stop_after_eight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel && act_q && int_rise && edg_q == LAST && !start) |=> !act_q);
endmodule

// File: rtl/ssx_tx.sv
module ssx_tx
  import ssx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  wr,
  input  char_t wdata,
  input  logic  fall_i,
  output logic  empty_o,
  output logic  sd_o
);
  localparam idx_t LAST = idx_t'(CHAR_BITS - 1);

  char_t hold_q, hold_d, sh_q, sh_d;
  idx_t  idx_q, idx_d, nxt;
  logic  busy_q, busy_d, empty_q, empty_d, sd_q, sd_d;

  assign nxt = idx_q + idx_t'(1);

  always_comb begin
    hold_d  = hold_q;
    sh_d    = sh_q;
    idx_d   = idx_q;
    busy_d  = busy_q;
    empty_d = empty_q;
    sd_d    = sd_q;
    if (fall_i) begin
      if (busy_q && idx_q != LAST) begin
        idx_d = nxt;
        sd_d  = sh_q[nxt];
      end else if (!empty_q && en) begin
        sh_d    = hold_q;
        sd_d    = hold_q[0];
        idx_d   = '0;
        busy_d  = 1'b1;
        empty_d = 1'b1;
      end else begin
        busy_d = 1'b0;
      end
    end
    if (wr) begin
      hold_d  = wdata;
      empty_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      sh_q    <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      empty_q <= 1'b1;
      sd_q    <= 1'b1;
    end else begin
      hold_q  <= hold_d;
      sh_q    <= sh_d;
      idx_q   <= idx_d;
      busy_q  <= busy_d;
      empty_q <= empty_d;
      sd_q    <= sd_d;
    end
  end

  assign empty_o = empty_q;
  assign sd_o    = sd_q;

  // R1 R5
  data_only_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_i |=> $stable(sd_q));

  // R6
  empty_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty_q) |-> $past(fall_i));
endmodule

// File: rtl/ssx_rx.sv
module ssx_rx
  import ssx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  rd,
  input  logic  sd_i,
  input  logic  rise_i,
  output char_t data_o,
  output logic  full_o,
  output logic  ovr_o
);
  localparam idx_t LAST = idx_t'(CHAR_BITS - 1);

  char_t sh_q, sh_d, data_q, data_d, shifted;
  idx_t  cnt_q, cnt_d;
  logic  full_q, full_d, ovr_q, ovr_d;

  assign shifted = {sd_i, sh_q[CHAR_BITS-1:1]};

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    data_d = data_q;
    full_d = full_q;
    ovr_d  = ovr_q;
    if (rd) begin
      full_d = 1'b0;
      ovr_d  = 1'b0;
    end
    if (!en) begin
      cnt_d = '0;
    end else if (rise_i) begin
      sh_d  = shifted;
      cnt_d = cnt_q + idx_t'(1);
      if (cnt_q == LAST) begin
        if (full_d) begin
          ovr_d = 1'b1;
        end else begin
          data_d = shifted;
          full_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      data_q <= data_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign ovr_o  = ovr_q;

  // R8
  keep_unread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !rd) |=> $stable(data_q));

  // R2
  full_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(rise_i));
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import ssx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk_sel,
  input  logic [DIV_W-1:0] div_n,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             tx_wr,
  input  logic [7:0]       tx_data,
  output logic             tx_empty,
  input  logic             rx_rd,
  output logic [7:0]       rx_data,
  output logic             rx_full,
  output logic             rx_overrun,
  input  logic             sck_in,
  output logic             sck_out,
  output logic             sck_oe,
  output logic             sd_out,
  input  logic             sd_in
);
  logic fall_p, rise_p, want_tx, rx_only;

  assign want_tx = tx_en & ~tx_empty;
  assign rx_only = rx_en & ~tx_en;
  assign sck_oe  = ~ext_clk_sel;

  ssx_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .ext_sel(ext_clk_sel), .div(div_n),
    .want_tx(want_tx), .rx_only(rx_only), .sck_in(sck_in),
    .fall_p(fall_p), .rise_p(rise_p), .sck_o(sck_out)
  );

  ssx_tx u_tx (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .wr(tx_wr), .wdata(tx_data),
    .fall_i(fall_p), .empty_o(tx_empty), .sd_o(sd_out)
  );

  ssx_rx u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .rd(rx_rd), .sd_i(sd_in),
    .rise_i(rise_p), .data_o(rx_data), .full_o(rx_full), .ovr_o(rx_overrun)
  );

  // R9
  ext_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_clk_sel |-> (!sck_oe && sck_out));
endmodule

// File: tb/sim_sync_serial_xcvr.sv
module sim_sync_serial_xcvr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_clk_sel = 1'b0, tx_en = 1'b0, rx_en = 1'b0, tx_wr = 1'b0;
  logic [7:0] div_n = 8'd1, tx_data = 8'd0;
  logic sck_in = 1'b1, sd_drv = 1'b0, loop = 1'b1;
  logic auto_rd = 1'b0, auto_pulse = 1'b0, man_rd = 1'b0;
  logic tx_empty, rx_full, rx_overrun, sck_out, sck_oe, sd_out;
  logic [7:0] rx_data;
  logic rx_rd, sd_in, line, prev_line;

  int vectors = 0, errors = 0, cyc = 0;
  logic [7:0] txq[$], rxq[$];
  logic [7:0] wbyte;
  int mbits = 0, rises = 0, brises = 0, last_rise = 0, exp_per = 4, rx_got = 0;
  logic mon_tx = 1'b0, chk_per = 1'b0;

  assign rx_rd = auto_pulse | man_rd;
  assign sd_in = loop ? sd_out : sd_drv;
  assign line  = ext_clk_sel ? sck_in : sck_out;

  always #5 clk = ~clk;

  sync_serial_xcvr u0 (
    .clk(clk), .rst_n(rst_n), .ext_clk_sel(ext_clk_sel), .div_n(div_n),
    .tx_en(tx_en), .rx_en(rx_en), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_empty(tx_empty), .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full),
    .rx_overrun(rx_overrun), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
    .sd_out(sd_out), .sd_in(sd_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  // monitor: wire-side scoreboard, period check, receive scoreboard
  initial prev_line = 1'b1;
  always @(posedge clk) begin
    #2;
    cyc++;
    if (!mon_tx) mbits = 0;
    if (!prev_line && line) begin
      rises++;
      if (chk_per) begin
        if (brises > 0)
          chk(cyc - last_rise == exp_per, "R3/R6 rise spacing", cyc - last_rise, exp_per);
        brises++;
      end
      last_rise = cyc;
      if (mon_tx) begin
        wbyte = {sd_out, wbyte[7:1]};
        mbits++;
        if (mbits == 8) begin
          mbits = 0;
          if (txq.size() > 0) begin
            logic [7:0] e;
            e = txq.pop_front();
            chk(wbyte == e, "R1 wire char", wbyte, e);
          end else chk(1'b0, "R1 unexpected wire char", wbyte, 0);
        end
      end
    end
    prev_line = line;
    if (auto_pulse) auto_pulse = 1'b0;
    else if (auto_rd && rx_full) begin
      rx_got++;
      if (rxq.size() > 0) begin
        logic [7:0] e;
        e = rxq.pop_front();
        chk(rx_data == e, "R2 received char", rx_data, e);
      end else chk(1'b0, "R2 unexpected received char", rx_data, 0);
      auto_pulse = 1'b1;
    end
    if (cyc > 100000) begin
      chk(1'b0, "watchdog", cyc, 100000);
      finish_run();
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!tx_empty) @(negedge clk);
    tx_wr = 1'b1;
    tx_data = b;
    txq.push_back(b);
    rxq.push_back(b);
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sck_in = 1'b0;
      idle(10);
      sck_in = 1'b1;
      idle(10);
    end
  endtask

  initial begin
    int r0;
    idle(3);
    // R10 reset state
    chk(tx_empty == 1'b1, "R10 tx_empty", tx_empty, 1);
    chk(rx_full == 1'b0 && rx_overrun == 1'b0, "R10 rx flags", {rx_full, rx_overrun}, 0);
    chk(sck_out == 1'b1 && sd_out == 1'b1, "R10 sck_out/sd_out", {sck_out, sd_out}, 3);
    rst_n = 1'b1;
    idle(2);
    chk(sck_oe == 1'b1, "R3 clock pin driven", sck_oe, 1);

    // full duplex loopback, divisor 1, back-to-back burst
    tx_en = 1'b1; rx_en = 1'b1; auto_rd = 1'b1; mon_tx = 1'b1;
    exp_per = 4; brises = 0; chk_per = 1'b1;
    r0 = rises;
    send(8'hA5); send(8'h3C); send(8'h01); send(8'h80);
    idle(120);
    chk_per = 1'b0;
    // R4 exactly 8 pulses per character
    chk(rises - r0 == 32, "R4 pulse count", rises - r0, 32);
    chk(sck_out == 1'b1, "R3 idle high", sck_out, 1);
    // R5 MSB held
    chk(sd_out == 1'b1, "R5 holds MSB 1", sd_out, 1);
    r0 = rises;
    idle(30);
    chk(rises == r0, "R4 clock stopped", rises - r0, 0);
    send(8'h7F);
    idle(60);
    chk(sd_out == 1'b0, "R5 holds MSB 0", sd_out, 0);

    // divisor 3
    div_n = 8'd3; exp_per = 8; brises = 0; chk_per = 1'b1;
    send(8'h5A); send(8'hC3);
    idle(200);
    chk_per = 1'b0;
    chk(txq.size() == 0 && rxq.size() == 0, "R1/R2 queues drained", txq.size() + rxq.size(), 0);

    // receive-only with overrun
    div_n = 8'd1; tx_en = 1'b0; auto_rd = 1'b0; mon_tx = 1'b0;
    loop = 1'b0; sd_drv = 1'b1;
    @(negedge clk);
    begin
      int t = 0;
      while (!rx_full && t < 500) begin @(negedge clk); t++; end
    end
    sd_drv = 1'b0;
    chk(rx_data == 8'hFF, "R2 receive-only char", rx_data, 8'hFF);
    r0 = rises;
    idle(200);
    // R7 clock keeps running
    chk(rises - r0 >= 45, "R7 continuous clocking", rises - r0, 50);
    chk(rx_overrun == 1'b1, "R8 overrun set", rx_overrun, 1);
    chk(rx_data == 8'hFF, "R8 unread data kept", rx_data, 8'hFF);
    rx_en = 1'b0;
    idle(60);
    r0 = rises;
    idle(40);
    chk(rises == r0 && sck_out == 1'b1, "R7 clock stops after rx_en clear", rises - r0, 0);
    man_rd = 1'b1;
    @(negedge clk);
    man_rd = 1'b0;
    @(negedge clk);
    chk(rx_full == 1'b0 && rx_overrun == 1'b0, "R8 read clears flags", {rx_full, rx_overrun}, 0);

    // external clock
    ext_clk_sel = 1'b1; loop = 1'b1; tx_en = 1'b1; rx_en = 1'b1;
    auto_rd = 1'b1; mon_tx = 1'b1; rx_got = 0;
    idle(2);
    chk(sck_oe == 1'b0, "R9 pin not driven", sck_oe, 0);
    send(8'h96);
    idle(50);
    chk(tx_empty == 1'b0, "R9 no shift without edges", tx_empty, 0);
    ext_pulses(8);
    send(8'h41);
    ext_pulses(8);
    idle(20);
    chk(rx_got == 2, "R9 external chars received", rx_got, 2);
    chk(txq.size() == 0 && rxq.size() == 0, "R9 queues drained", txq.size() + rxq.size(), 0);
    chk(sd_out == 1'b0, "R5 ext holds MSB", sd_out, 0);

    finish_run();
  end
endmodule